// File: doc/BRIEF.md
# Vectored Interrupt Controller with Register Port

This block gathers a configurable number of peripheral interrupt lines (one to thirty-two) and presents them to a processor through a small synchronous 32-bit register port. Each line is fixed at build time as edge or level sensitive. Requests are captured into a status word. They are qualified by per-line enable bits, and the result is a pending word. A single active-high interrupt line goes to the processor. A vector register names the lowest-numbered pending line, so a handler can loop reading it until it returns all ones.

Software manages the enables in three ways: a plain write of the whole enable word, or atomic set and clear writes that touch only the bits written as 1. Sources are acknowledged by writing ones to an acknowledge register. A two-bit control register holds a global enable and an output-arm bit. Until the output-arm bit is set, software may raise test requests by writing the status register.

The register port is plain and single-cycle: a write takes effect at the clock edge where the write strobe is sampled. Read data is registered and appears one cycle after the read strobe. It holds its value while no read is issued. The port has no back-pressure; every access completes.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset, status, enable and the control register all read 0, the vector reads 0xFFFFFFFF and `irq_o` is low.
- R2: A line whose kind bit is 1 (edge; lines 4 to 7 with the default kind mask) sets its status bit on a 0-to-1 transition. The bit stays set after the line falls and is cleared only by an acknowledge. A line held high after its acknowledge does not set the bit again.
- R3: A line whose kind bit is 0 (level; lines 0 to 3 by default) sets its status bit on every clock while it is high, so an acknowledge written while the line is high leaves the bit set. Once the line is low, an acknowledge clears the bit.
- R4: A write to word offset 0x08 replaces the enable word. A write to 0x10 sets the enable bits written as 1. A write to 0x14 clears the enable bits written as 1. Bits written as 0 to 0x10 or 0x14 keep their value.
- R5: Writing 1 to a bit at offset 0x0C clears that status bit. Writing 0xFFFFFFFF clears every status bit.
- R6: Offset 0x04 reads the pending word, which is status AND enable.
- R7: Offset 0x18 reads the index of the lowest-numbered pending bit, or 0xFFFFFFFF when no bit is pending.
- R8: At offset 0x1C, bit 0 is the global enable and bit 1 is the output-arm bit. Writing 0x3 reads back exactly 0x3. Bit 0 follows every write. Bit 1, once set, stays set until reset.
- R9: `irq_o` is high exactly when the global enable, the output-arm bit and at least one pending bit are all 1.
- R10: While the output-arm bit is 0, writing offset 0x00 sets the status bits written as 1. Once the arm bit is 1, writes to 0x00 have no effect.
- R11: Register bits for lines at or above the line count, and bits 31:2 of the control register, read as 0. Kind-mask bits at or above the line count have no effect.
- R12: `bus_rdata` shows the addressed register one cycle after `bus_rd` is sampled, and keeps its value in cycles with no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | N_SRC | Peripheral interrupt lines, synchronous to clk |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 5 | Byte address, word aligned (bits 1:0 ignored) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Active-high interrupt to the processor |

## Verification
The capture path is driven with a single pulse on an edge line, an edge line held high across its acknowledge, and a level line held high across its acknowledge and then released. Together these separate edge capture from level capture and show whether an acknowledge loses to a live request. The vector is read with one bit pending, with two pending bits where the lower one is masked, after the lower one is acknowledged, and with nothing pending. These cases separate a lowest-index encoder from a highest-index one and from one that ignores the enables. The output line is checked with only the global enable set, then with both control bits set, then with only the arm bit left. This shows that both bits gate the line and that the arm bit cannot be cleared.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 5;

  // Word offsets within the register window (byte address bits 4:2).
  typedef enum logic [2:0] {
    OFF_STAT = 3'd0,
    OFF_PEND = 3'd1,
    OFF_EN   = 3'd2,
    OFF_ACK  = 3'd3,
    OFF_SET  = 3'd4,
    OFF_CLR  = 3'd5,
    OFF_VEC  = 3'd6,
    OFF_CTL  = 3'd7
  } reg_off_e;

  // Control register bit positions.
  localparam int unsigned CTL_GEN_BIT = 0;
  localparam int unsigned CTL_ARM_BIT = 1;

  localparam logic [DATA_W-1:0] VEC_NONE = '1;
endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank #(
  parameter int unsigned N_SRC     = 8,
  parameter logic [31:0] KIND_MASK = 32'h0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] irq_in,
  input  logic [N_SRC-1:0] ack_mask,
  input  logic [N_SRC-1:0] sw_set,
  output logic [N_SRC-1:0] status
);
  logic [N_SRC-1:0] prev_q;
  logic [N_SRC-1:0] hw_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= irq_in;
  end

  for (genvar i = 0; i < N_SRC; i++) begin : g_line
    if (KIND_MASK[i]) begin : g_edge
      assign hw_set[i] = irq_in[i] & ~prev_q[i];

      p_edge_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (status[i] && !ack_mask[i]) |=> status[i])
        else $error("edge status bit %0d dropped without acknowledge", i);
    end else begin : g_level
      assign hw_set[i] = irq_in[i];

      p_level_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_in[i] |=> status[i])
        else $error("level line %0d high but status clear", i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status[i] <= 1'b0;
      else        status[i] <= hw_set[i] | sw_set[i] | (status[i] & ~ack_mask[i]);
    end

    p_ack_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_mask[i] && !hw_set[i] && !sw_set[i]) |=> !status[i])
      else $error("acknowledge of line %0d did not clear status", i);
  end
endmodule

// File: rtl/irq_lowest_enc.sv
module irq_lowest_enc #(
  parameter int unsigned N_SRC = 8,
  localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0] req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end

  assign any = |req;
endmodule

// File: rtl/irq_reg_port.sv
module irq_reg_port
  import irq_vec_pkg::*;
#(
  parameter int unsigned N_SRC = 8,
  localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [N_SRC-1:0]  status,
  input  logic [N_SRC-1:0]  pending,
  input  logic              vec_any,
  input  logic [IDX_W-1:0]  vec_idx,
  output logic [N_SRC-1:0]  enable,
  output logic [N_SRC-1:0]  ack_mask,
  output logic [N_SRC-1:0]  sw_set,
  output logic              gen_en,
  output logic              arm_en
);
  reg_off_e          off;
  logic [N_SRC-1:0]  wmask;
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] stat_w, pend_w, en_w, vec_w;
  logic              unused_addr_bits;

  assign off   = reg_off_e'(bus_addr[4:2]);
  assign wmask = bus_wdata[N_SRC-1:0];
  assign unused_addr_bits = ^{bus_addr[1:0], bus_wdata};

  assign ack_mask = (bus_wr && off == OFF_ACK) ? wmask : '0;
  assign sw_set   = (bus_wr && off == OFF_STAT && !arm_en) ? wmask : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable <= '0;
      gen_en <= 1'b0;
      arm_en <= 1'b0;
    end else if (bus_wr) begin
      unique case (off)
        OFF_EN:  enable <= wmask;
        OFF_SET: enable <= enable | wmask;
        OFF_CLR: enable <= enable & ~wmask;
        OFF_CTL: begin
          gen_en <= bus_wdata[CTL_GEN_BIT];
          arm_en <= arm_en | bus_wdata[CTL_ARM_BIT];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    stat_w = '0;
    pend_w = '0;
    en_w   = '0;
    vec_w  = '0;
    stat_w[N_SRC-1:0] = status;
    pend_w[N_SRC-1:0] = pending;
    en_w[N_SRC-1:0]   = enable;
    vec_w[IDX_W-1:0]  = vec_idx;
    if (!vec_any) vec_w = VEC_NONE;
    unique case (off)
      OFF_STAT: rd_mux = stat_w;
      OFF_PEND: rd_mux = pend_w;
      OFF_EN:   rd_mux = en_w;
      OFF_VEC:  rd_mux = vec_w;
      OFF_CTL: begin
        rd_mux = '0;
        rd_mux[CTL_GEN_BIT] = gen_en;
        rd_mux[CTL_ARM_BIT] = arm_en;
      end
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  p_arm_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    arm_en |=> arm_en)
    else $error("output-arm bit cleared after being set");

  p_set_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && off == OFF_SET) |=> ((enable & $past(wmask)) == $past(wmask)))
    else $error("set-enable write left a bit clear");

  p_clr_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && off == OFF_CLR) |=> ((enable & $past(wmask)) == '0))
    else $error("clear-enable write left a bit set");

  p_rdata_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata))
    else $error("read data changed without a read");
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import irq_vec_pkg::*;
#(
  parameter int unsigned N_SRC     = 8,
  parameter logic [31:0] KIND_MASK = 32'hFFFF_FFF0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  irq_in,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o
);
  localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

  logic [N_SRC-1:0] status, enable, pending, ack_mask, sw_set, below_mask;
  logic             vec_any, gen_en, arm_en;
  logic [IDX_W-1:0] vec_idx;

  irq_src_bank #(.N_SRC(N_SRC), .KIND_MASK(KIND_MASK)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_in   (irq_in),
    .ack_mask (ack_mask),
    .sw_set   (sw_set),
    .status   (status)
  );

  assign pending = status & enable;

  irq_lowest_enc #(.N_SRC(N_SRC)) u_enc (
    .req (pending),
    .any (vec_any),
    .idx (vec_idx)
  );

  irq_reg_port #(.N_SRC(N_SRC)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .status    (status),
    .pending   (pending),
    .vec_any   (vec_any),
    .vec_idx   (vec_idx),
    .enable    (enable),
    .ack_mask  (ack_mask),
    .sw_set    (sw_set),
    .gen_en    (gen_en),
    .arm_en    (arm_en)
  );

  assign irq_o = gen_en & arm_en & vec_any;

  assign below_mask = (N_SRC'(1) << vec_idx) - N_SRC'(1);

  p_vec_lowest_r7: assert property (@(posedge clk) disable iff (!rst_n)
    vec_any |-> (pending[vec_idx] && ((pending & below_mask) == '0)))
    else $error("vector does not name the lowest pending line");

  p_irq_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (gen_en && arm_en && (pending != '0)))
    else $error("interrupt output raised without both enables and a pending line");
endmodule

// File: tb/irq_vec_ctrl_tb.sv
module irq_vec_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  localparam logic [4:0] A_STAT = 5'h00, A_PEND = 5'h04, A_EN  = 5'h08, A_ACK = 5'h0C;
  localparam logic [4:0] A_SET  = 5'h10, A_CLR  = 5'h14, A_VEC = 5'h18, A_CTL = 5'h1C;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  irq_in = '0;
  logic          bus_wr = 1'b0, bus_rd = 1'b0;
  logic [4:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          irq_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_vec_ctrl #(.N_SRC(N), .KIND_MASK(32'hFFFF_FFF0)) u_dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic apply_reset();
    rst_n = 1'b0; irq_in = '0; bus_wr = 1'b0; bus_rd = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    apply_reset();
    check("R1 irq_o after reset", 32'(irq_o), 32'h0);
    rd(A_STAT, d); check("R1 status after reset", d, 32'h0);
    rd(A_EN, d);   check("R1 enable after reset", d, 32'h0);
    rd(A_CTL, d);  check("R1 control after reset", d, 32'h0);
    rd(A_VEC, d);  check("R1 vector after reset", d, 32'hFFFF_FFFF);
  endtask

  task automatic t_edge();
    logic [31:0] d;
    apply_reset();
    wr(A_SET, 32'h20);
    wr(A_CTL, 32'h3);
    irq_in[5] = 1'b1; @(negedge clk);
    check("R2/R9 irq_o after edge on line 5", 32'(irq_o), 32'h1);
    irq_in[5] = 1'b0; @(negedge clk); @(negedge clk);
    rd(A_STAT, d); check("R2 edge status held after line fell", d, 32'h20);
    wr(A_ACK, 32'h20);
    check("R12 rdata held without read", bus_rdata, 32'h20);
    check("R2 irq_o after acknowledge", 32'(irq_o), 32'h0);
    rd(A_STAT, d); check("R2 status cleared by acknowledge", d, 32'h0);
    irq_in[5] = 1'b1; @(negedge clk);
    wr(A_ACK, 32'h20);
    @(negedge clk);
    rd(A_STAT, d); check("R2 held edge line does not re-set", d, 32'h0);
    irq_in[5] = 1'b0;
  endtask

  task automatic t_level();
    logic [31:0] d;
    apply_reset();
    wr(A_EN, 32'h02);
    wr(A_CTL, 32'h3);
    irq_in[1] = 1'b1; @(negedge clk);
    rd(A_STAT, d); check("R3 level status set", d, 32'h02);
    wr(A_ACK, 32'h02);
    rd(A_STAT, d); check("R3 acknowledge while high has no effect", d, 32'h02);
    check("R9 irq_o with level pending", 32'(irq_o), 32'h1);
    irq_in[1] = 1'b0; @(negedge clk);
    rd(A_STAT, d); check("R3 status latched after line fell", d, 32'h02);
    wr(A_ACK, 32'h02);
    rd(A_STAT, d); check("R3 acknowledge after release clears", d, 32'h0);
    check("R9 irq_o low after level cleared", 32'(irq_o), 32'h0);
  endtask

  task automatic t_enable();
    logic [31:0] d;
    apply_reset();
    wr(A_EN, 32'h0F);  rd(A_EN, d); check("R4 plain enable write", d, 32'h0F);
    wr(A_SET, 32'h30); rd(A_EN, d); check("R4 set-enable ORs bits", d, 32'h3F);
    wr(A_CLR, 32'h05); rd(A_EN, d); check("R4 clear-enable clears bits", d, 32'h3A);
    wr(A_EN, 32'hFFFF_FFFF); rd(A_EN, d); check("R11 enable upper bits read zero", d, 32'hFF);
    wr(A_CTL, 32'hFFFF_FFFF); rd(A_CTL, d); check("R11/R8 control upper bits read zero", d, 32'h3);
  endtask

  task automatic t_vector_and_control();
    logic [31:0] d;
    apply_reset();
    wr(A_STAT, 32'h0000_0128);
    rd(A_STAT, d); check("R10 status write sets bits before arm", d, 32'h28);
    wr(A_EN, 32'h08);
    rd(A_PEND, d); check("R6 pending is status and enable", d, 32'h08);
    rd(A_VEC, d);  check("R7 vector single pending", d, 32'h3);
    wr(A_EN, 32'h28);
    rd(A_VEC, d);  check("R7 vector picks lowest of two", d, 32'h3);
    wr(A_CLR, 32'h08);
    rd(A_VEC, d);  check("R7 vector skips masked lower line", d, 32'h5);
    wr(A_SET, 32'h08);
    wr(A_CTL, 32'h1);
    check("R9 irq_o low with arm clear", 32'(irq_o), 32'h0);
    wr(A_CTL, 32'h3);
    rd(A_CTL, d); check("R8 control reads 0x3", d, 32'h3);
    check("R9 irq_o high with both bits", 32'(irq_o), 32'h1);
    wr(A_STAT, 32'h80);
    rd(A_STAT, d); check("R10 status write ignored after arm", d, 32'h28);
    wr(A_ACK, 32'h08);
    rd(A_VEC, d);  check("R5/R7 vector after acknowledging line 3", d, 32'h5);
    wr(A_CTL, 32'h0);
    rd(A_CTL, d); check("R8 arm bit sticky", d, 32'h2);
    check("R9 irq_o low with global enable clear", 32'(irq_o), 32'h0);
    wr(A_ACK, 32'hFFFF_FFFF);
    rd(A_STAT, d); check("R5 acknowledge-all clears status", d, 32'h0);
    rd(A_VEC, d);  check("R7 vector none pending", d, 32'hFFFF_FFFF);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_edge();
    t_level();
    t_enable();
    t_vector_and_control();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule